// File: doc/BRIEF.md
# Memory-Operand Add Execution Unit

This block executes a single register-memory add instruction for a 16-bit load/store processor. When `start` is pulsed in the idle state with a word whose top four bits hold the add-from-memory opcode, the unit decodes the word. It takes the value of the first source register as a word address and reads that word through a request/ready memory port. It then adds either a second register or a sign-extended 5-bit constant to the fetched word. The sum goes to the destination register, and the sign, zero and positive flags are refreshed from it.

The controller moves through five named states. `ST_IDLE` waits for an accepted start; this is transition T1, IDLE to ADDR. `ST_ADDR` latches the masked address and the second operand, then moves on unconditionally (T2, ADDR to READ). `ST_READ` drives the read request and stays there while ready is low (T3, READ to READ). When ready is high, it captures the data word (T4, READ to EXEC). `ST_EXEC` writes the sum and flags back (T5, EXEC to DONE). `ST_DONE` raises `done` for one cycle and returns to idle (T6, DONE to IDLE). An eight-entry register file sits inside the unit. A preload port fills it while the unit is idle, and an inspection port reads it back at any time.

Top module: `madd_unit`

## Requirements
- R1: An instruction starts only when `start` is high in the idle state and `instr[15:12]` equals 4'b1010. Any other opcode is ignored: `busy` stays low, no read is made and no register or flag changes.
- R2: The fields are destination `instr[11:9]`, first source `instr[8:6]`, mode `instr[5]`, second source `instr[2:0]` and constant `instr[4:0]`. In register mode, `instr[4:3]` is ignored.
- R3: With `instr[5]`=0, the destination receives the memory word addressed by the first source plus the second-source register.
- R4: With `instr[5]`=1, the destination receives that memory word plus `instr[4:0]` sign-extended to 16 bits.
- R5: `mem_addr` equals the first-source value with bit 0 forced to 0. `mem_rd` stays high, and `mem_addr` stays stable, until `mem_ready` is sampled high.
- R6: Timing: `busy` rises in the cycle after acceptance. There is one address cycle, then read cycles that end with the first ready cycle, then one write-back cycle, then one `done` cycle. `busy` is therefore high for 4 plus the number of wait cycles, and `done` is a single-cycle pulse.
- R7: `cc` is {N,Z,P} with exactly one bit set. It changes only at write-back: N if bit 15 of the result is set, Z if the result is zero, P otherwise.
- R8: The result is correct when the destination and both sources name the same register.
- R9: `pre_we` writes `pre_data` into register `pre_idx` only while `busy` is low. While `busy` is high, the write is ignored. `peek_data` always shows register `peek_idx`.
- R10: After reset, the unit is idle, `done` and `mem_rd` are low, `cc` is 3'b010 and all registers read zero.
- R11: The addition is modulo 2^16 and has no carry output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in the idle state |
| instr | input | 16 | Instruction word |
| busy | output | 1 | High from ADDR to DONE |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Word-aligned read address |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Read data valid |
| cc | output | 3 | Flags {N,Z,P} |
| pre_we | input | 1 | Preload write enable |
| pre_idx | input | 3 | Preload register index |
| pre_data | input | 16 | Preload data |
| peek_idx | input | 3 | Inspection register index |
| peek_data | output | 16 | Inspection register value |

## Verification
The assertions check, on every cycle, that the read request and its address are held until ready, that `done` lasts one cycle and follows a write-back, that the flags are one-hot and move only at write-back, and that an unknown opcode keeps the controller idle. Only the bench's scenarios can show that the arithmetic is right. These cover the register and constant modes, negative constants, wraparound, the zero and negative flag outcomes, and the case where one register is used for all three operands. The scenarios also show that preloads made during an operation are dropped and that wait states lengthen `busy` by the right amount.

// File: rtl/madd_pkg.sv
package madd_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_REGS  = 8;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int IMM_W     = 5;
    localparam int CC_W      = 3;
    localparam logic [3:0] OPC_MADD = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_EXEC,
        ST_DONE
    } madd_state_e;

    // Decoded view of the instruction word.
    typedef struct packed {
        logic [3:0]           opc;
        logic [REG_IDX_W-1:0] dst;
        logic [REG_IDX_W-1:0] src_a;
        logic                 use_imm;
        logic [IMM_W-1:0]     low;
    } madd_instr_t;

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    // Flags ordered {N,Z,P}.
    function automatic logic [CC_W-1:0] flags_of(input logic [WORD_W-1:0] v);
        logic [CC_W-1:0] f;
        if (v[WORD_W-1])  f = 3'b100;
        else if (v == '0) f = 3'b010;
        else              f = 3'b001;
        return f;
    endfunction

endpackage

// File: rtl/madd_regfile.sv
module madd_regfile
    import madd_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NUM_REGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] ra_idx,
    output logic [W-1:0]         ra_data,
    input  logic [$clog2(N)-1:0] rb_idx,
    output logic [W-1:0]         rb_data,
    input  logic [$clog2(N)-1:0] rc_idx,
    output logic [W-1:0]         rc_data,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);
    localparam int IW = $clog2(N);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    // Three independent combinational read ports.
    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign rc_data = regs[rc_idx];

    logic [IW-1:0] unused_w;
    assign unused_w = wa;

endmodule

// File: rtl/madd_ctrl.sv
module madd_ctrl
    import madd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [3:0]  opc,
    input  logic        mem_ready,
    output madd_state_e state,
    output logic        ld_ir,
    output logic        ld_mar,
    output logic        ld_mdr,
    output logic        wb,
    output logic        mem_rd,
    output logic        busy,
    output logic        done
);
    madd_state_e nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and per-state strobes.
    always_comb begin
        nxt    = state;
        ld_ir  = 1'b0;
        ld_mar = 1'b0;
        ld_mdr = 1'b0;
        wb     = 1'b0;
        mem_rd = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (start && opc == OPC_MADD) begin
                    ld_ir = 1'b1;
                    nxt   = ST_ADDR;
                end
            end
            ST_ADDR: begin
                ld_mar = 1'b1;
                nxt    = ST_READ;
            end
            ST_READ: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    ld_mdr = 1'b1;
                    nxt    = ST_EXEC;
                end
            end
            ST_EXEC: begin
                wb  = 1'b1;
                nxt = ST_DONE;
            end
            ST_DONE: begin
                done = 1'b1;
                nxt  = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> mem_rd);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && opc != OPC_MADD) |=> !busy);

endmodule

// File: rtl/madd_dpath.sv
module madd_dpath
    import madd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int IW = REG_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   instr,
    input  logic          ld_ir,
    input  logic          ld_mar,
    input  logic          ld_mdr,
    input  logic          wb,
    input  logic [W-1:0]  src_a_val,
    input  logic [W-1:0]  src_b_val,
    input  logic [W-1:0]  mem_rdata,
    output logic [IW-1:0] src_a_idx,
    output logic [IW-1:0] src_b_idx,
    output logic [IW-1:0] dst_idx,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  wb_data,
    output logic [CC_W-1:0] cc
);
    madd_instr_t ir;
    logic [W-1:0] mar, opb, mdr;

    assign src_a_idx = ir.src_a;
    assign src_b_idx = ir.low[IW-1:0];
    assign dst_idx   = ir.dst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir  <= '0;
            mar <= '0;
            opb <= '0;
            mdr <= '0;
            cc  <= 3'b010;
        end else begin
            if (ld_ir) ir <= madd_instr_t'(instr);
            // Both sources are captured here, before any write-back.
            if (ld_mar) begin
                mar <= {src_a_val[W-1:1], 1'b0};
                opb <= ir.use_imm ? sext_imm(ir.low) : src_b_val;
            end
            if (ld_mdr) mdr <= mem_rdata;
            if (wb)     cc  <= flags_of(wb_data);
        end
    end

    assign mem_addr = mar;
    assign wb_data  = mdr + opb;

    // R7
    cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);

endmodule

// File: rtl/madd_unit.sv
module madd_unit
    import madd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] instr,
    output logic        busy,
    output logic        done,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ready,
    output logic [2:0]  cc,
    input  logic        pre_we,
    input  logic [2:0]  pre_idx,
    input  logic [15:0] pre_data,
    input  logic [2:0]  peek_idx,
    output logic [15:0] peek_data
);
    madd_state_e state;
    logic ld_ir, ld_mar, ld_mdr, wb;
    logic [REG_IDX_W-1:0] a_idx, b_idx, d_idx, w_idx;
    logic [WORD_W-1:0] a_val, b_val, wb_data, w_data;
    logic rf_we;

    madd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .opc(instr[15:12]),
        .mem_ready(mem_ready), .state(state), .ld_ir(ld_ir), .ld_mar(ld_mar),
        .ld_mdr(ld_mdr), .wb(wb), .mem_rd(mem_rd), .busy(busy), .done(done)
    );

    madd_dpath u_dpath (
        .clk(clk), .rst_n(rst_n), .instr(instr), .ld_ir(ld_ir), .ld_mar(ld_mar),
        .ld_mdr(ld_mdr), .wb(wb), .src_a_val(a_val), .src_b_val(b_val),
        .mem_rdata(mem_rdata), .src_a_idx(a_idx), .src_b_idx(b_idx),
        .dst_idx(d_idx), .mem_addr(mem_addr), .wb_data(wb_data), .cc(cc)
    );

    // Write-back has the port; preloads are accepted only while idle.
    assign rf_we  = wb | (pre_we & ~busy);
    assign w_idx  = wb ? d_idx : pre_idx;
    assign w_data = wb ? wb_data : pre_data;

    madd_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(a_idx), .ra_data(a_val),
        .rb_idx(b_idx), .rb_data(b_val),
        .rc_idx(peek_idx), .rc_data(peek_data),
        .we(rf_we), .wa(w_idx), .wd(w_data)
    );

    // R5
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> $stable(mem_addr));

    // R6
    done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb |=> done);

    // R7
    cc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb |=> $stable(cc));

    // R9
    busy_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wb) |=> $stable(peek_data) || $changed(peek_idx));

endmodule

// File: tb/sim_madd_unit.sv
`timescale 1ns/100ps
module sim_madd_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] instr = '0;
    logic busy, done, mem_rd;
    logic [15:0] mem_addr, mem_rdata;
    logic mem_ready = 1'b0;
    logic [2:0] cc;
    logic pre_we = 1'b0;
    logic [2:0] pre_idx = '0;
    logic [15:0] pre_data = '0;
    logic [2:0] peek_idx = '0;
    logic [15:0] peek_data;

    always #2.5 clk = ~clk;

    madd_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy),
        .done(done), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .cc(cc), .pre_we(pre_we), .pre_idx(pre_idx),
        .pre_data(pre_data), .peek_idx(peek_idx), .peek_data(peek_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Memory model: 64 words.
    logic [15:0] bmem [64];
    assign mem_rdata = bmem[mem_addr[6:1]];

    int lat = 0;
    int wcnt = 0;
    always @(posedge clk) begin
        #1;
        if (mem_rd) begin
            mem_ready = (wcnt >= lat);
            wcnt++;
        end else begin
            wcnt = 0;
            mem_ready = 1'b0;
        end
    end

    // Behavioural reference model.
    int mph = 0;
    logic [15:0] m_rf [8];
    logic [15:0] m_ir, m_addr, m_opb, m_mdr, m_res;
    logic [2:0]  m_cc = 3'b010;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mph = 0;
            for (int i = 0; i < 8; i++) m_rf[i] = '0;
            m_cc = 3'b010;
            m_addr = '0;
        end else begin
            case (mph)
                0: begin
                    if (pre_we) m_rf[pre_idx] = pre_data;
                    if (start && instr[15:12] == 4'hA) begin
                        m_ir = instr;
                        mph = 1;
                    end
                end
                1: begin
                    m_addr = m_rf[m_ir[8:6]] & 16'hFFFE;
                    m_opb  = m_ir[5] ? {{11{m_ir[4]}}, m_ir[4:0]} : m_rf[m_ir[2:0]];
                    mph = 2;
                end
                2: if (mem_ready) begin
                    m_mdr = bmem[m_addr[6:1]];
                    mph = 3;
                end
                3: begin
                    m_res = m_mdr + m_opb;
                    m_rf[m_ir[11:9]] = m_res;
                    m_cc = m_res[15] ? 3'b100 : (m_res == 16'h0 ? 3'b010 : 3'b001);
                    mph = 4;
                end
                default: mph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6 busy", busy, mph != 0);
            chk("R6 done", done, mph == 4);
            chk("R5 mem_rd", mem_rd, mph == 2);
            if (mph == 2) chk("R5 mem_addr", mem_addr, m_addr);
            chk("R7 cc", cc, m_cc);
            chk("R9 peek", peek_data, m_rf[peek_idx]);
        end
    end

    function automatic logic [15:0] enc(input int d, input int s1, input bit m, input logic [4:0] lo);
        return {4'hA, 3'(d), 3'(s1), m, lo};
    endfunction

    task automatic preload(input int idx, input logic [15:0] v);
        @(posedge clk); #1;
        pre_we = 1'b1; pre_idx = 3'(idx); pre_data = v;
        @(posedge clk); #1;
        pre_we = 1'b0;
    endtask

    task automatic peek(input string tag, input int idx, input logic [15:0] exp);
        peek_idx = 3'(idx);
        #0.5;
        chk(tag, peek_data, exp);
    endtask

    task automatic run_op(input logic [15:0] iw, input int lt, input bit poke, output int bcyc);
        lat = lt;
        @(posedge clk); #1;
        start = 1'b1; instr = iw;
        @(posedge clk); #1;
        start = 1'b0;
        bcyc = 0;
        if (poke) begin
            pre_we = 1'b1; pre_idx = 3'd7; pre_data = 16'hDEAD;
            @(posedge clk); #1;
            pre_we = 1'b0;
            bcyc = 1;
        end
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (busy) bcyc++;
            if (done) break;
        end
    endtask

    int bc;

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 16'(i * 16'h0123 + 16'h0011);
        bmem[16] = 16'h1000;
        bmem[17] = 16'h0001;
        bmem[4]  = 16'h0100;
        #12 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 mem_rd", mem_rd, 0);
        chk("R10 cc", cc, 3'b010);
        for (int i = 0; i < 8; i++) peek("R10 reg zero", i, 16'h0);

        preload(1, 16'h0020);
        preload(2, 16'h0005);
        preload(4, 16'h0023);
        preload(5, 16'h0007);
        preload(6, 16'h0008);
        preload(7, 16'h1111);
        peek("R9 preload", 4, 16'h0023);

        // R3 register mode, two wait cycles
        run_op(enc(3, 1, 0, 5'd2), 2, 0, bc);
        chk("R6 busy length lat2", bc, 6);
        peek("R3 reg mode sum", 3, 16'h1005);
        chk("R7 positive", cc, 3'b001);

        // R4 negative constant, odd address (R5)
        run_op(enc(0, 4, 1, 5'b11101), 1, 0, bc);
        chk("R6 busy length lat1", bc, 5);
        peek("R4 neg imm", 0, 16'hFFFE);
        chk("R7 negative", cc, 3'b100);

        // R7 zero result, no wait
        bmem[17] = 16'h0003;
        run_op(enc(0, 4, 1, 5'b11101), 0, 0, bc);
        chk("R6 busy length lat0", bc, 4);
        peek("R4 zero sum", 0, 16'h0000);
        chk("R7 zero", cc, 3'b010);

        // R11 wraparound
        bmem[16] = 16'hFFFF;
        run_op(enc(3, 1, 0, 5'd2), 1, 0, bc);
        peek("R11 wrap", 3, 16'h0004);
        chk("R11 wrap flag", cc, 3'b001);

        // R8 one register for all operands
        run_op(enc(6, 6, 0, 5'd6), 1, 0, bc);
        peek("R8 alias", 6, 16'h0108);

        // R4 largest positive constant
        run_op(enc(2, 1, 1, 5'b01111), 0, 0, bc);
        peek("R4 imm max", 2, 16'h000E);

        // R2 register mode ignores bits 4:3
        run_op(enc(3, 1, 0, 5'b11101), 3, 0, bc);
        peek("R2 ignore bits", 3, 16'h0006);

        // R1 unknown opcode ignored
        lat = 0;
        @(posedge clk); #1;
        start = 1'b1; instr = 16'h1A85;
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 bad opcode busy", busy, 0);
            chk("R1 bad opcode rd", mem_rd, 0);
        end
        peek("R1 bad opcode regs", 3, 16'h0006);
        chk("R1 bad opcode cc", cc, 3'b001);

        // R9 preload during operation dropped
        run_op(enc(3, 1, 0, 5'd2), 3, 1, bc);
        peek("R9 busy preload", 7, 16'h1111);
        peek("R3 after poke", 3, 16'h000D);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule